// File: doc/BRIEF.md
# Key Matrix Scanner with Key Request

This block reads a key matrix with 8 source lines and 4 return lines. A frame timing generator outside the block supplies the key-scan phases. In each phase the scanner pulls one source line low and reads the four return inputs, which have pull-ups. When the phase ends, it writes the pressed keys for that source into a 32-bit key store. A serial interface reads the store one byte at a time by byte address. Each byte holds two sources.

A request flag tells the host that key data is present. While scanning, the flag is high as long as any stored bit is set. Reading the store does not clear it. In standby the store is frozen and the return inputs stay pulled up. Any pressed key then sets a wake flag, and the request output follows the wake flag. When scanning is stopped the request stays low, but the stored data can still be read.

Top module: `keyscan_top`

## Requirements
- R1: While reset is held and after it is released, the store reads all zeros, `key_req` and `wake_req` are 0, and every `src_drv_n` bit is 1.
- R2: While scanning is active (`scan_en`=1, `standby`=0) and `phase_act`=1, only `src_drv_n[phase_idx]` is 0. Index 0 is the first source and index 7 the last. In every other case all bits are 1.
- R3: `pullup_en` is 1 whenever `standby`=1. It is also 1 while scanning is active and `phase_act`=1. Otherwise it is 0.
- R4: A store write happens in a cycle where scanning is active, `phase_act`=1 and `phase_end`=1. The write sets bit r of that source to the inverse of `key_in[r]` (pressed reads 1). The new value is readable from the next cycle; in the write cycle the old value is still read. A phase without `phase_end` changes nothing.
- R5: The byte at `rd_addr`=a has source 7−2a in bits 7:4 and source 6−2a in bits 3:0. Inside each nibble, return input 3 is the MSB and return input 0 the LSB. Addresses 0 to 3 therefore read the source pairs from the top pair down.
- R6: While scanning is active, `key_req` is 1 exactly when any stored bit is 1. It falls only once every bit is 0. Reads do not clear it.
- R7: With `scan_en`=0 and `standby`=0, `key_req` is 0. Phases leave the store unchanged and the store stays readable.
- R8: In standby, nothing is written to the store. Any `key_in` bit at 0 sets `wake_req` on the next edge, and `key_req` follows `wake_req`. `wake_req` stays set while standby lasts, even after the key is released. It clears on the first edge after standby ends.
- R9: Standby overrides `scan_en`: no source is driven and a stored key does not raise `key_req`.
- R10: `key_byte` follows `rd_addr` within the same cycle, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_en | input | 1 | Key scanning enabled |
| standby | input | 1 | Standby mode |
| phase_act | input | 1 | A key-scan phase is in progress |
| phase_end | input | 1 | Last clock of the current phase |
| phase_idx | input | 3 | Source index of the current phase |
| key_in | input | 4 | Return inputs, low when a key on the driven source is pressed |
| rd_addr | input | 2 | Key byte address |
| src_drv_n | output | 8 | Source lines, active low |
| key_byte | output | 8 | Addressed key byte |
| pullup_en | output | 1 | Enable for the return-input pull-ups |
| key_req | output | 1 | Key request flag |
| wake_req | output | 1 | Standby wake request |

## Verification
Two events can fall in the same cycle: a read of a key byte and the store write at the end of a phase that updates that same byte. The bench keeps `rd_addr` on the target byte through the end-of-phase clock. It checks that the old byte is read in that cycle and the new byte in the next. A second case is a release scan that clears the last set bit. `key_req` must stay high through all earlier clears and fall in the cycle after the final clear, whatever reads happened in between.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;

  typedef enum logic [1:0] {
    KM_IDLE  = 2'd0,
    KM_SCAN  = 2'd1,
    KM_SLEEP = 2'd2
  } kmode_t;

  // standby wins over scan enable
  function automatic kmode_t mode_of(input logic scan_en, input logic standby);
    if (standby)      return KM_SLEEP;
    else if (scan_en) return KM_SCAN;
    else              return KM_IDLE;
  endfunction

  // source index placed in a byte: upper nibble for lower=0, lower nibble for lower=1
  function automatic int pair_src(input int byte_idx, input int n_src, input bit lower);
    return n_src - 1 - 2 * byte_idx - (lower ? 1 : 0);
  endfunction

endpackage

// File: rtl/keyscan_drive.sv
module keyscan_drive
  import keyscan_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int IDX_W = 3
) (
  input  kmode_t           mode,
  input  logic             phase_act,
  input  logic             phase_end,
  input  logic [IDX_W-1:0] phase_idx,
  output logic [N_SRC-1:0] src_drv_n,
  output logic             pullup_en,
  output logic             store_wr
);

  logic scanning;
  assign scanning = (mode == KM_SCAN) && phase_act;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    assign src_drv_n[s] = !(scanning && (phase_idx == IDX_W'(s)));
  end

  assign pullup_en = (mode == KM_SLEEP) || scanning;
  assign store_wr  = scanning && phase_end;

endmodule

// File: rtl/keyscan_store.sv
module keyscan_store
  import keyscan_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int N_RET  = 4,
  parameter int IDX_W  = 3,
  parameter int ADDR_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [N_RET-1:0]   key_in,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [2*N_RET-1:0] rd_byte,
  output logic               any_set
);

  localparam int N_BYTE = N_SRC / 2;

  logic [N_RET-1:0]   rows     [N_SRC];
  logic [2*N_RET-1:0] byte_tab [N_BYTE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < N_SRC; s++) rows[s] <= '0;
    end else if (wr_en) begin
      for (int s = 0; s < N_SRC; s++)
        if (wr_idx == IDX_W'(s)) rows[s] <= ~key_in;
    end
  end

  for (genvar b = 0; b < N_BYTE; b++) begin : g_byte
    localparam int HI = pair_src(b, N_SRC, 1'b0);
    localparam int LO = pair_src(b, N_SRC, 1'b1);
    assign byte_tab[b] = {rows[HI], rows[LO]};
  end

  always_comb begin
    rd_byte = '0;
    for (int b = 0; b < N_BYTE; b++)
      if (rd_addr == ADDR_W'(b)) rd_byte = byte_tab[b];
  end

  always_comb begin
    any_set = 1'b0;
    for (int s = 0; s < N_SRC; s++) any_set = any_set | (|rows[s]);
  end

endmodule

// File: rtl/keyscan_req.sv
module keyscan_req
  import keyscan_pkg::*;
#(
  parameter int N_RET = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  kmode_t           mode,
  input  logic             any_set,
  input  logic [N_RET-1:0] key_in,
  output logic             key_req,
  output logic             wake_req
);

  logic any_low;
  assign any_low = ~&key_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 wake_req <= 1'b0;
    else if (mode != KM_SLEEP)  wake_req <= 1'b0;
    else if (any_low)           wake_req <= 1'b1;
  end

  always_comb begin
    case (mode)
      KM_SCAN:  key_req = any_set;
      KM_SLEEP: key_req = wake_req;
      default:  key_req = 1'b0;
    endcase
  end

endmodule

// File: rtl/keyscan_top.sv
module keyscan_top
  import keyscan_pkg::*;
#(
  parameter  int N_SRC  = 8,
  parameter  int N_RET  = 4,
  localparam int IDX_W  = $clog2(N_SRC),
  localparam int ADDR_W = $clog2(N_SRC / 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scan_en,
  input  logic               standby,
  input  logic               phase_act,
  input  logic               phase_end,
  input  logic [IDX_W-1:0]   phase_idx,
  input  logic [N_RET-1:0]   key_in,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [N_SRC-1:0]   src_drv_n,
  output logic [2*N_RET-1:0] key_byte,
  output logic               pullup_en,
  output logic               key_req,
  output logic               wake_req
);

  kmode_t mode;
  logic   store_wr;
  logic   any_set;

  assign mode = mode_of(scan_en, standby);

  keyscan_drive #(.N_SRC(N_SRC), .IDX_W(IDX_W)) drive_i (
    .mode      (mode),
    .phase_act (phase_act),
    .phase_end (phase_end),
    .phase_idx (phase_idx),
    .src_drv_n (src_drv_n),
    .pullup_en (pullup_en),
    .store_wr  (store_wr)
  );

  keyscan_store #(.N_SRC(N_SRC), .N_RET(N_RET), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (store_wr),
    .wr_idx  (phase_idx),
    .key_in  (key_in),
    .rd_addr (rd_addr),
    .rd_byte (key_byte),
    .any_set (any_set)
  );

  keyscan_req #(.N_RET(N_RET)) req_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .any_set  (any_set),
    .key_in   (key_in),
    .key_req  (key_req),
    .wake_req (wake_req)
  );

endmodule

// File: rtl/keyscan_chk.sv
module keyscan_chk #(
  parameter int N_SRC  = 8,
  parameter int N_RET  = 4,
  parameter int IDX_W  = 3,
  parameter int ADDR_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scan_en,
  input logic               standby,
  input logic               phase_act,
  input logic [IDX_W-1:0]   phase_idx,
  input logic [N_RET-1:0]   key_in,
  input logic [ADDR_W-1:0]  rd_addr,
  input logic [N_SRC-1:0]   src_drv_n,
  input logic [2*N_RET-1:0] key_byte,
  input logic               pullup_en,
  input logic               key_req,
  input logic               wake_req,
  input logic               store_wr,
  input logic               any_set
);

  a_r2_one_low: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~src_drv_n) <= 1);

  a_r2_selected_low: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && !standby && phase_act) |-> !src_drv_n[phase_idx]);

  a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_act || standby || !scan_en) |-> (src_drv_n == '1));

  a_r3_pull_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> pullup_en);

  a_r6_req_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && !standby) |-> (key_req == any_set));

  a_r7_req_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && !standby) |-> !key_req);

  a_r8_wake_set: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(standby) && standby && ($past(key_in) != '1)) |-> wake_req);

  a_r8_wake_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!standby && $past(!standby)) |-> !wake_req);

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!store_wr) && $stable(rd_addr)) |-> $stable(key_byte));

endmodule

bind keyscan_top keyscan_chk #(
  .N_SRC(N_SRC), .N_RET(N_RET), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .scan_en   (scan_en),
  .standby   (standby),
  .phase_act (phase_act),
  .phase_idx (phase_idx),
  .key_in    (key_in),
  .rd_addr   (rd_addr),
  .src_drv_n (src_drv_n),
  .key_byte  (key_byte),
  .pullup_en (pullup_en),
  .key_req   (key_req),
  .wake_req  (wake_req),
  .store_wr  (store_wr),
  .any_set   (any_set)
);

// File: tb/keyscan_top_tb_top.sv
module keyscan_top_tb_top;

  localparam int CLK_NS = 20;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scan_en, standby, phase_act, phase_end;
  logic [2:0] phase_idx;
  logic [3:0] key_in;
  logic [1:0] rd_addr;
  logic [7:0] src_drv_n, key_byte;
  logic       pullup_en, key_req, wake_req;

  int checks = 0;
  int errors = 0;
  logic [3:0] mdl [8];

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } sb_t;
  sb_t sbq[$];

  always #(CLK_NS/2) clk = ~clk;

  keyscan_top dut_i (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .standby(standby),
    .phase_act(phase_act), .phase_end(phase_end), .phase_idx(phase_idx),
    .key_in(key_in), .rd_addr(rd_addr), .src_drv_n(src_drv_n),
    .key_byte(key_byte), .pullup_en(pullup_en), .key_req(key_req),
    .wake_req(wake_req)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected byte, built bit by bit from the stated layout
  function automatic logic [7:0] mbyte(input int a);
    logic [7:0] v;
    for (int k = 0; k < 8; k++) begin
      int src;
      src  = (k >= 4) ? (7 - 2*a) : (6 - 2*a);
      v[k] = mdl[src][k % 4];
    end
    return v;
  endfunction

  function automatic logic m_any();
    logic r = 1'b0;
    for (int s = 0; s < 8; s++) r = r | (|mdl[s]);
    return r;
  endfunction

  // driver: set the address, push the expected byte
  task automatic rd_expect(input int a, input string tag);
    @(negedge clk);
    rd_addr = 2'(a);
    #3;
    sbq.push_back('{mbyte(a), tag});
  endtask

  // monitor: compare after the address has settled
  initial begin
    forever begin
      @(negedge clk);
      #6;
      while (sbq.size() > 0) begin
        sb_t it;
        it = sbq.pop_front();
        chk(32'(key_byte), 32'(it.exp), it.tag);
      end
    end
  end

  task automatic do_phase(input int idx, input logic [3:0] pressed, input bit with_end, input string tag);
    logic [7:0] exp_drv;
    @(negedge clk);
    phase_idx = 3'(idx); phase_act = 1'b1; phase_end = 1'b0; key_in = ~pressed;
    @(negedge clk);
    exp_drv = (scan_en && !standby) ? ~(8'b1 << idx) : 8'hFF;
    chk(32'(src_drv_n), 32'(exp_drv), {tag, " R2 drive"});
    chk(32'(pullup_en), 32'(standby | scan_en), {tag, " R3 pullup"});
    phase_end = with_end;
    @(negedge clk);
    phase_end = 1'b0; phase_act = 1'b0; key_in = 4'hF;
    if (with_end && scan_en && !standby) mdl[idx] = pressed;
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_NS * 150000);
    checks++; errors++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    for (int s = 0; s < 8; s++) mdl[s] = 4'h0;
    rst_n = 1'b0; scan_en = 1'b0; standby = 1'b0; phase_act = 1'b0;
    phase_end = 1'b0; phase_idx = 3'd0; key_in = 4'hF; rd_addr = 2'd0;
    repeat (3) @(negedge clk);
    chk(32'(src_drv_n), 32'hFF, "R1 drive in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(32'(key_req), 0, "R1 key_req");
    chk(32'(wake_req), 0, "R1 wake_req");
    chk(32'(src_drv_n), 32'hFF, "R1 drive");
    chk(32'(pullup_en), 0, "R3 pullup idle");
    for (int a = 0; a < 4; a++) rd_expect(a, "R1 store zero");

    // scanning
    scan_en = 1'b1;
    do_phase(0, 4'b0000, 1, "p0");
    chk(32'(key_req), 0, "R6 no key");
    do_phase(7, 4'b1000, 1, "p7");
    rd_expect(0, "R5 top source upper nibble");
    chk(32'(key_req), 1, "R6 key present");
    do_phase(6, 4'b0001, 1, "p6");
    do_phase(0, 4'b0101, 1, "p0b");
    do_phase(3, 4'b0010, 1, "p3");
    for (int a = 0; a < 4; a++) rd_expect(a, "R5 R10 byte layout");
    #2 chk(32'(key_req), 1, "R6 reads do not clear");

    // phase without an end strobe
    do_phase(2, 4'b1111, 0, "p2 noend");
    rd_expect(2, "R4 no write without phase_end");

    // read of the byte written in the same cycle
    @(negedge clk);
    rd_addr = 2'd0; phase_idx = 3'd7; phase_act = 1'b1; key_in = ~4'b0100;
    @(negedge clk);
    phase_end = 1'b1;
    #2 chk(32'(key_byte), 32'(mbyte(0)), "R4 old value in write cycle");
    @(negedge clk);
    phase_end = 1'b0; phase_act = 1'b0; key_in = 4'hF;
    mdl[7] = 4'b0100;
    #2 chk(32'(key_byte), 32'(mbyte(0)), "R4 new value next cycle");
    chk(32'(key_byte), 32'h41, "R5 updated byte");

    // release scan: request falls only after the last bit clears
    do_phase(7, 4'b0000, 1, "rel7");
    do_phase(6, 4'b0000, 1, "rel6");
    do_phase(0, 4'b0000, 1, "rel0");
    #2 chk(32'(key_req), 1, "R6 still set");
    do_phase(3, 4'b0000, 1, "rel3");
    #2 chk(32'(key_req), 32'(m_any()), "R6 falls when all clear");
    chk(32'(key_req), 0, "R6 low");

    // scanning stopped
    do_phase(5, 4'b0011, 1, "p5");
    #2 chk(32'(key_req), 1, "R6 set again");
    @(negedge clk); scan_en = 1'b0;
    #2 chk(32'(key_req), 0, "R7 low when stopped");
    do_phase(5, 4'b1100, 1, "stop p5");
    rd_expect(1, "R7 store kept and readable");
    chk(32'h30, 32'(mbyte(1)), "R7 model byte");

    // standby overrides scan enable
    @(negedge clk); scan_en = 1'b1; standby = 1'b1;
    #2 chk(32'(pullup_en), 1, "R3 pullup in standby");
    chk(32'(key_req), 0, "R9 stored key hidden in standby");
    chk(32'(src_drv_n), 32'hFF, "R9 no drive");
    do_phase(4, 4'b0000, 1, "sb p4");
    @(negedge clk); key_in = ~4'b0010;
    @(negedge clk);
    chk(32'(wake_req), 1, "R8 wake set");
    chk(32'(key_req), 1, "R8 key_req follows wake");
    key_in = 4'hF;
    @(negedge clk);
    chk(32'(wake_req), 1, "R8 wake held");
    do_phase(1, 4'b1000, 1, "sb p1");
    rd_expect(3, "R8 no store in standby");
    @(negedge clk); standby = 1'b0;
    @(negedge clk);
    chk(32'(wake_req), 0, "R8 wake cleared");
    chk(32'(key_req), 32'(m_any()), "R6 back to store");
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule